// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit sits beside an I2C bus engine and turns the engine's single-cycle event pulses into sticky flags. The flags are arbitration lost, no-acknowledge, access-ready, receive-ready, transmit-ready, stop-detected and addressed-as-slave. Software reads the flags through a status register and clears them by writing ones. A separate enable register selects which flags may raise the interrupt line. A read-only vector register returns a small code for the most urgent enabled flag, so an interrupt handler can dispatch with one read.

Reading the vector with the read strobe asserted retires the flag it reported. The two data-ready flags are the exception: the receive-ready flag clears only when the receive data is fetched, and the transmit-ready flag clears only when new transmit data is written. The status register also shows a bus-busy bit, which follows START and STOP detection, and a level from the engine that reports a full receive shift register.

Top module: `i2c_irq_vec`

## Requirements
- R1: After reset the status, enable and vector registers all read 0 and `irq` is low.
- R2: A pulse on `ev_pulse[i]` sets flag i, which reads back at status bit i from the following cycle. The event order is: 0 arbitration lost, 1 no-acknowledge, 2 access-ready, 3 receive-ready, 4 transmit-ready, 5 stop-detected, 6 addressed-as-slave.
- R3: A write to the status register (address 0) clears every flag whose data bit is 1 and leaves flags under 0 bits unchanged. If an event pulse and a clear hit the same flag in the same cycle, the flag stays set.
- R4: The enable register (address 1) stores `reg_wdata[6:0]`. Bit i enables event i. Bits 15:7 read as 0.
- R5: `irq` is high exactly when some flag is set and its enable bit is 1. With the enable register at 0, `irq` stays low while the flags still update.
- R6: The vector register (address 2) reads, in bits 2:0, code i+1 for the lowest-numbered set and enabled flag i, so arbitration lost is 1 and addressed-as-slave is 7. It reads 0 when no enabled flag is set.
- R7: A read of the vector register with `reg_rd` high clears the reported flag at the next clock edge, for codes 1, 2, 3, 6 and 7.
- R8: A vector read does not clear code 4 (receive-ready) or code 5 (transmit-ready). A `rx_data_rd` pulse clears receive-ready, and a `tx_data_wr` pulse clears transmit-ready.
- R9: Status bit 12 (bus busy) is set by `ev_start` and cleared by the stop-detected pulse `ev_pulse[5]`. When both arrive in the same cycle, busy is set.
- R10: Status bit 11 shows the `rs_full` input level in the same cycle. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 7 | One-cycle event pulses from the bus engine, ordered as listed in R2 |
| ev_start | input | 1 | START condition detected |
| rs_full | input | 1 | Receive shift register full (level) |
| rx_data_rd | input | 1 | Receive data register was read |
| tx_data_wr | input | 1 | Transmit data register was written |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 vector |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (enables the vector-read side effect) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Read data, the vector code and `irq` are combinational from registered state. A flag therefore appears in all three one clock edge after its event pulse, enable write or clear. A read-clear or data-access clear likewise takes effect at the next edge. The bench drives inputs on the falling edge and reads the outputs one falling edge later, just after the single register stage. Comparisons of `rs_full` and of the vector returned during a clearing read are made in the same cycle, before the edge.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
    localparam int NUM_EVT  = 7;
    localparam int CODE_W   = $clog2(NUM_EVT + 1);
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 2;
    localparam int EVT_RX   = 3;
    localparam int EVT_TX   = 4;
    localparam int EVT_STOP = 5;

    typedef logic [NUM_EVT-1:0] evt_vec_t;
    typedef logic [CODE_W-1:0]  code_t;

    typedef enum logic [ADDR_W-1:0] {
        REG_STAT = 2'd0,
        REG_MASK = 2'd1,
        REG_VEC  = 2'd2
    } reg_sel_e;

    // flags that a vector read must not retire (data-access driven)
    localparam evt_vec_t KEEP_ON_VEC = evt_vec_t'((1 << EVT_RX) | (1 << EVT_TX));
endpackage

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags
    import i2c_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_vec_t set_i,
    input  evt_vec_t w1c_i,
    input  evt_vec_t data_clr_i,
    input  logic     vec_clr_i,
    input  code_t    vec_code_i,
    output evt_vec_t flags_o
);
    typedef struct packed {
        evt_vec_t flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_EVT; i++) begin
            logic vclr;
            vclr = vec_clr_i && (vec_code_i == code_t'(i + 1)) && !KEEP_ON_VEC[i];
            st_d.flags[i] = set_i[i] |
                            (st_q.flags[i] & ~w1c_i[i] & ~data_clr_i[i] & ~vclr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/i2c_evt_prio.sv
module i2c_evt_prio
    import i2c_irq_pkg::*;
(
    input  evt_vec_t req_i,
    output code_t    code_o
);
    always_comb begin
        code_o = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (req_i[i]) code_o = code_t'(i + 1);
        end
    end
endmodule

// File: rtl/i2c_bus_busy.sv
module i2c_bus_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic busy_o
);
    typedef struct packed {
        logic busy;
    } busy_st_t;

    busy_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i)     st_d.busy = 1'b1;
        else if (stop_i) st_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = st_q.busy;
endmodule

// File: rtl/i2c_irq_vec.sv
module i2c_irq_vec
    import i2c_irq_pkg::*;
#(
    parameter int RSF_BIT  = 11,
    parameter int BUSY_BIT = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  ev_pulse,
    input  logic                ev_start,
    input  logic                rs_full,
    input  logic                rx_data_rd,
    input  logic                tx_data_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq
);
    typedef struct packed {
        evt_vec_t mask;
    } ctl_st_t;

    ctl_st_t  ctl_d, ctl_q;
    evt_vec_t flags;
    evt_vec_t mask;
    evt_vec_t pend;
    evt_vec_t w1c;
    evt_vec_t data_clr;
    code_t    vec;
    logic     busy;
    logic     vec_rd;
    logic     wdata_hi_unused;

    assign wdata_hi_unused = ^reg_wdata[DATA_W-1:NUM_EVT];

    // register-port decode
    always_comb begin
        ctl_d    = ctl_q;
        w1c      = '0;
        vec_rd   = reg_rd && (reg_addr == REG_VEC);
        data_clr = '0;
        data_clr[EVT_RX] = rx_data_rd;
        data_clr[EVT_TX] = tx_data_wr;
        if (reg_wr && reg_addr == REG_STAT) w1c        = reg_wdata[NUM_EVT-1:0];
        if (reg_wr && reg_addr == REG_MASK) ctl_d.mask = reg_wdata[NUM_EVT-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign mask = ctl_q.mask;

    i2c_evt_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ev_pulse),
        .w1c_i      (w1c),
        .data_clr_i (data_clr),
        .vec_clr_i  (vec_rd),
        .vec_code_i (vec),
        .flags_o    (flags)
    );

    assign pend = flags & mask;

    i2c_evt_prio u_prio (
        .req_i  (pend),
        .code_o (vec)
    );

    i2c_bus_busy u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ev_start),
        .stop_i  (ev_pulse[EVT_STOP]),
        .busy_o  (busy)
    );

    assign irq = |pend;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_STAT: begin
                reg_rdata[NUM_EVT-1:0] = flags;
                reg_rdata[RSF_BIT]     = rs_full;
                reg_rdata[BUSY_BIT]    = busy;
            end
            REG_MASK: reg_rdata[NUM_EVT-1:0] = mask;
            REG_VEC:  reg_rdata[CODE_W-1:0]  = vec;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_irq_vec_chk.sv
module i2c_irq_vec_chk
    import i2c_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input evt_vec_t          ev_pulse,
    input logic              ev_start,
    input logic              rx_data_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input evt_vec_t          wbits,
    input evt_vec_t          flags,
    input evt_vec_t          mask,
    input code_t             vec,
    input logic              busy,
    input logic              irq
);
    evt_vec_t pick;
    always_comb begin
        pick = '0;
        if (vec != '0) pick = evt_vec_t'(1) << (vec - code_t'(1));
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        // R2: a pulse sets its flag
        a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
            ev_pulse[i] |=> flags[i]);
        // R3: a write of one without a new event clears
        a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == 2'd0 && wbits[i] && !ev_pulse[i]) |=> !flags[i]);
    end

    a_r5_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    a_r6_irq_vec: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (vec != '0));

    a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != '0) |-> (((flags & mask & pick) != '0) &&
                         ((flags & mask & (pick - evt_vec_t'(1))) == '0)));

    a_r7_vec_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2 && vec == code_t'(1) && !ev_pulse[0]) |=> !flags[0]);

    a_r8_rx_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd2 && vec == code_t'(4) && !rx_data_rd) |=> flags[EVT_RX]);

    a_r9_start: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> busy);

    a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_pulse[EVT_STOP] && !ev_start) |=> !busy);
endmodule

bind i2c_irq_vec i2c_irq_vec_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_pulse   (ev_pulse),
    .ev_start   (ev_start),
    .rx_data_rd (rx_data_rd),
    .reg_addr   (reg_addr),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .wbits      (reg_wdata[i2c_irq_pkg::NUM_EVT-1:0]),
    .flags      (flags),
    .mask       (mask),
    .vec        (vec),
    .busy       (busy),
    .irq        (irq)
);

// File: tb/tb_i2c_irq_vec.sv
module tb_i2c_irq_vec;
    localparam int CLK_PERIOD = 10;
    localparam int NROW = 9;
    // {enable, events, expected vector, expected irq}
    localparam logic [17:0] TBL [NROW] = '{
        {7'h7F, 7'h01, 3'd1, 1'b1},
        {7'h7F, 7'h44, 3'd3, 1'b1},
        {7'h7F, 7'h60, 3'd6, 1'b1},
        {7'h7E, 7'h03, 3'd2, 1'b1},
        {7'h00, 7'h7F, 3'd0, 1'b0},
        {7'h40, 7'h7F, 3'd7, 1'b1},
        {7'h08, 7'h18, 3'd4, 1'b1},
        {7'h7F, 7'h00, 3'd0, 1'b0},
        {7'h10, 7'h10, 3'd5, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ev_pulse = '0;
    logic        ev_start = 1'b0;
    logic        rs_full = 1'b0;
    logic        rx_data_rd = 1'b0;
    logic        tx_data_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_irq_vec dut (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .ev_start(ev_start),
        .rs_full(rs_full), .rx_data_rd(rx_data_rd), .tx_data_wr(tx_data_wr),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [6:0] e);
        ev_pulse = e;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, d); check("R1 status", d, 16'h0000);
        rd(2'd1, d); check("R1 enable", d, 16'h0000);
        rd(2'd2, d); check("R1 vector", d, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);

        // table walk: R2, R5, R6
        for (int r = 0; r < NROW; r++) begin
            wr(2'd0, 16'h007F);
            wr(2'd1, {9'd0, TBL[r][17:11]});
            pulse(TBL[r][10:4]);
            rd(2'd2, d); check("R6 vector", d, {13'd0, TBL[r][3:1]});
            check("R5 irq", {15'd0, irq}, {15'd0, TBL[r][0]});
            rd(2'd0, d); check("R2 status", d, {9'd0, TBL[r][10:4]});
        end

        // R3: partial clear, zero write, set wins over clear
        wr(2'd0, 16'h007F);
        pulse(7'h7F);
        wr(2'd0, 16'h0005);
        rd(2'd0, d); check("R3 partial clear", d, 16'h007A);
        wr(2'd0, 16'h0000);
        rd(2'd0, d); check("R3 zero write", d, 16'h007A);
        ev_pulse = 7'h01;
        wr(2'd0, 16'h0001);
        ev_pulse = '0;
        rd(2'd0, d); check("R3 set wins", d, 16'h007B);

        // R4: enable register width
        wr(2'd1, 16'hFFFF);
        rd(2'd1, d); check("R4 enable readback", d, 16'h007F);

        // R7: vector read retires the reported flag
        wr(2'd0, 16'h007F);
        pulse(7'h03);
        reg_addr = 2'd2; reg_rd = 1'b1; #1;
        check("R7 vector during read", reg_rdata, 16'h0001);
        @(negedge clk); reg_rd = 1'b0;
        rd(2'd2, d); check("R7 next vector", d, 16'h0002);
        rd(2'd0, d); check("R7 status after read", d, 16'h0002);

        // R8: receive-ready survives vector read, cleared by data read
        wr(2'd0, 16'h007F);
        pulse(7'h08);
        reg_addr = 2'd2; reg_rd = 1'b1; #1;
        check("R8 rx vector", reg_rdata, 16'h0004);
        @(negedge clk); reg_rd = 1'b0;
        rd(2'd0, d); check("R8 rx kept", d, 16'h0008);
        rx_data_rd = 1'b1; @(negedge clk); rx_data_rd = 1'b0;
        rd(2'd0, d); check("R8 rx cleared", d, 16'h0000);
        // transmit-ready
        pulse(7'h10);
        reg_addr = 2'd2; reg_rd = 1'b1; #1;
        check("R8 tx vector", reg_rdata, 16'h0005);
        @(negedge clk); reg_rd = 1'b0;
        rd(2'd0, d); check("R8 tx kept", d, 16'h0010);
        tx_data_wr = 1'b1; @(negedge clk); tx_data_wr = 1'b0;
        rd(2'd0, d); check("R8 tx cleared", d, 16'h0000);
        check("R8 irq low", {15'd0, irq}, 16'h0000);

        // R9: bus busy
        ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
        rd(2'd0, d); check("R9 busy set", d, 16'h1000);
        pulse(7'h20);
        rd(2'd0, d); check("R9 busy cleared", d, 16'h0020);
        wr(2'd0, 16'h007F);
        ev_start = 1'b1; ev_pulse = 7'h20;
        @(negedge clk);
        ev_start = 1'b0; ev_pulse = '0;
        rd(2'd0, d); check("R9 start wins", d, 16'h1020);

        // R10: shift-full level and unused address
        wr(2'd0, 16'h007F);
        ev_pulse = 7'h20; @(negedge clk); ev_pulse = '0;
        rs_full = 1'b1;
        rd(2'd0, d); check("R10 rs_full shown", d, 16'h0820);
        rs_full = 1'b0;
        rd(2'd0, d); check("R10 rs_full dropped", d, 16'h0020);
        rd(2'd3, d); check("R10 unused address", d, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule